// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked on-chip request port and an external asynchronous static RAM of 131072 bytes. It has a 17-bit address bus and an 8-bit data path. Each request is either one read or one write. The controller turns it into a pin-level cycle on the RAM. Every strobe phase lasts a whole number of clock cycles. That number is derived at elaboration from the nanosecond minimums of the memory and the clock period: the minimum is divided by the period and rounded up. The defaults assume a 10 ns clock.

The RAM is enabled only when two chip selects of opposite polarity are both in their active state. The controller keeps them deselected between transactions, with write enable and output enable high. It drives the shared data bus only during a write. After a read it leaves a quiet interval so that the memory outputs can reach high impedance. A read returns its byte together with a one-cycle done pulse. A write reports completion the same way. The request port accepts a new command only while the controller is idle.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and whenever the controller is idle, the pins are quiet. mem_sel_n is 1, mem_sel is 0, mem_oe_n is 1, mem_we_n is 1 and mem_dq_oe is 0. req_ready is 1 only in the idle state.
- R2: mem_sel_n and mem_sel always carry opposite levels. The memory counts as selected when mem_sel_n is 0 and mem_sel is 1. That happens only during a read access window or during the setup, pulse or recovery phase of a write.
- R3: An accepted read starts on the next cycle. For RD_CYC = ceil(55 ns / period) cycles the memory is selected, mem_oe_n is 0 and mem_we_n is 1. Throughout those cycles mem_addr holds the requested address unchanged.
- R4: Read data is sampled from mem_dq_in in the last cycle of the access window. It appears on rsp_rdata in the following cycle, while rsp_done is 1 for exactly that one cycle.
- R5: A read access window is followed by TURN_CYC = ceil(20 ns / period) cycles with the memory deselected, mem_oe_n at 1, mem_dq_oe at 0 and req_ready at 0. The controller then returns to idle.
- R6: An accepted write runs through three phases. First comes one setup cycle in which the memory is selected, data is driven and mem_we_n is 1. Next come WR_CYC = ceil(45 ns / period) cycles with mem_we_n at 0. Last comes one recovery cycle with mem_we_n back at 1, data still driven and the memory still selected. The controller then goes idle, and rsp_done is 1 in that first idle cycle.
- R7: mem_dq_oe is 1 only during the three write phases, and never while mem_oe_n is 0. At least one cycle with mem_dq_oe at 0 precedes every fall of mem_oe_n. At least TURN_CYC cycles with mem_oe_n at 1 and no drive precede every rise of mem_dq_oe.
- R8: A request presented while req_ready is 0 is ignored. It leaves no trace on the pins and no trace in the memory contents.
- R9: Written bytes land at exactly the requested address across the full 17-bit range, including 0 and 131071, and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; taken only while req_ready is 1 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 17 | Byte address of the request |
| req_wdata | input | 8 | Byte to store on a write |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Address pins of the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 8 | Data returned from the memory pins |

## Verification
Two situations are hard to reach from the ports. The first is the handover from a read to a write, where the turnaround gap and the release of the data drive are exercised. The bench creates it by queuing a write whose request is raised in the very cycle req_ready comes back after a read, so the write starts as early as the controller allows. The second is a command arriving while the controller is busy. The bench holds a write request on the port for several cycles in the middle of a read, drops it before the read ends, and later reads that address to show that nothing was stored. The memory model returns valid data only after output enable has been low for the full access window. A window that is too short or a capture that comes too early therefore shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_REC   = 3'd5
  } seq_state_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int period_ns);
    int cyc;
    cyc = (t_ns + period_ns - 1) / period_ns;
    if (cyc < 1) cyc = 1;
    return cyc;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) pipe_q <= 1'b0;
        else              pipe_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) pipe_q <= '0;
        else              pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW       = 3,
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 5,
  parameter int TURN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_expired,
  output seq_state_t    state_q,
  output seq_state_t    nxt_state,
  output logic          accept,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          capture,
  output logic          done_set
);

  localparam logic [CW-1:0] RD_LOAD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LOAD   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] TURN_LOAD = CW'(TURN_CYC - 1);

  always_comb begin
    nxt_state = state_q;
    accept    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture   = 1'b0;
    done_set  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            nxt_state = ST_WR_SETUP;
          end else begin
            nxt_state = ST_RD_ACC;
            tmr_load  = 1'b1;
            tmr_val   = RD_LOAD;
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_expired) begin
          nxt_state = ST_RD_TURN;
          tmr_load  = 1'b1;
          tmr_val   = TURN_LOAD;
          capture   = 1'b1;
          done_set  = 1'b1;
        end
      end
      ST_RD_TURN: begin
        if (tmr_expired) nxt_state = ST_IDLE;
      end
      ST_WR_SETUP: begin
        nxt_state = ST_WR_PULSE;
        tmr_load  = 1'b1;
        tmr_val   = WR_LOAD;
      end
      ST_WR_PULSE: begin
        if (tmr_expired) nxt_state = ST_WR_REC;
      end
      ST_WR_REC: begin
        nxt_state = ST_IDLE;
        done_set  = 1'b1;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt_state;
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_t    nxt_state,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic          done_set,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);

  // Bit i set means select i is active high.
  localparam logic [1:0] SEL_POL = 2'b10;

  logic sel_d, oe_low_d, we_low_d, drive_d;
  logic [1:0] cs_q;

  always_comb begin
    sel_d    = (nxt_state == ST_RD_ACC)   || (nxt_state == ST_WR_SETUP) ||
               (nxt_state == ST_WR_PULSE) || (nxt_state == ST_WR_REC);
    oe_low_d = (nxt_state == ST_RD_ACC);
    we_low_d = (nxt_state == ST_WR_PULSE);
    drive_d  = (nxt_state == ST_WR_SETUP) || (nxt_state == ST_WR_PULSE) ||
               (nxt_state == ST_WR_REC);
  end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cs
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q[i] <= ~SEL_POL[i];
        else        cs_q[i] <= sel_d ? SEL_POL[i] : ~SEL_POL[i];
      end
    end
  endgenerate

  assign mem_sel_n = cs_q[0];
  assign mem_sel   = cs_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
    end else begin
      mem_oe_n  <= ~oe_low_d;
      mem_we_n  <= ~we_low_d;
      mem_dq_oe <= drive_d;
      rsp_done  <= done_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_addr <= '0;
    else if (accept) mem_addr <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mem_dq_out <= '0;
    else if (accept && req_write)    mem_dq_out <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_in;
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int CLK_PERIOD_NS  = 10,
  parameter int T_RD_ACCESS_NS = 55,
  parameter int T_WR_PULSE_NS  = 45,
  parameter int T_TURN_NS      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = ns_to_cycles(T_RD_ACCESS_NS, CLK_PERIOD_NS);
  localparam int WR_CYC   = ns_to_cycles(T_WR_PULSE_NS, CLK_PERIOD_NS);
  localparam int TURN_CYC = ns_to_cycles(T_TURN_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC  = max3(RD_CYC, WR_CYC, TURN_CYC);
  localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic          rst_n_sync;
  seq_state_t    state_q, nxt_state;
  logic          accept, tmr_load, tmr_expired, capture, done_set;
  logic [CW-1:0] tmr_val;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  sram_wait_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .CW       (CW),
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .state_q     (state_q),
    .nxt_state   (nxt_state),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .capture     (capture),
    .done_set    (done_set)
  );

  sram_pin_regs #(.AW(ADDR_W), .DW(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .nxt_state  (nxt_state),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .done_set   (done_set),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 5,
  parameter int TURN_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  int we_run, oe_run, hiz_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run  <= 0;
      oe_run  <= 0;
      hiz_cnt <= TURN_CYC;
    end else begin
      we_run <= mem_we_n ? 0 : we_run + 1;
      oe_run <= mem_oe_n ? 0 : oe_run + 1;
      if (!mem_oe_n)                              hiz_cnt <= 0;
      else if (!mem_dq_oe && hiz_cnt < TURN_CYC)  hiz_cnt <= hiz_cnt + 1;
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_sel_opposite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n != mem_sel);

  assert_oe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RD_CYC));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !$past(mem_sel_n)) |-> $stable(mem_addr));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_turn_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (hiz_cnt >= TURN_CYC));

  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WR_CYC));

  assert_we_context_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_dq_oe));

  assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_release_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .RD_CYC   (RD_CYC),
  .WR_CYC   (WR_CYC),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .mem_addr  (mem_addr),
  .mem_sel_n (mem_sel_n),
  .mem_sel   (mem_sel),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_bus_ctrl.sv
module sim_sram_bus_ctrl;

  localparam int PER  = 8;
  localparam int E_RD = (55 + PER - 1) / PER;
  localparam int E_WR = (45 + PER - 1) / PER;
  localparam int E_TN = (20 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #4 clk = ~clk;

  sram_bus_ctrl #(.CLK_PERIOD_NS(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Memory model and shadow of expected contents.
  bit [7:0] sram [int];
  bit [7:0] shadow [int];
  int rd_run = 0, wr_run = 0;
  bit [7:0] wr_byte;
  bit [16:0] wr_at;

  // Reference model: kind 0 idle, 1 read, 2 write; t = edges since accept.
  bit        model_on = 0;
  int        m_kind = 0, m_t = 0;
  bit        m_wdone = 0;
  bit [16:0] m_addr;
  bit [7:0]  m_data;

  always @(posedge clk) begin
    if (model_on) begin
      m_wdone = 0;
      if (m_kind == 0) begin
        if (req_valid) begin
          m_kind = req_write ? 2 : 1;
          m_t    = 0;
          m_addr = req_addr;
          if (req_write) begin
            m_data = req_wdata;
            shadow[int'(req_addr)] = req_wdata;
          end else begin
            m_data = shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'h00;
          end
        end
      end else begin
        m_t++;
        if (m_kind == 1 && m_t >= E_RD + E_TN) m_kind = 0;
        else if (m_kind == 2 && m_t >= E_WR + 2) begin
          m_kind  = 0;
          m_wdone = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    bit e_sel, e_oe_low, e_we_low, e_drive, e_ready, e_done;
    string tg;
    // Memory behaviour seen at the pins.
    if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) rd_run++;
    else rd_run = 0;
    mem_dq_in = (rd_run >= E_RD) ?
                (sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00) : 8'hEE;
    if (!mem_sel_n && mem_sel && !mem_we_n) begin
      wr_run++;
      wr_byte = mem_dq_oe ? mem_dq_out : 8'hEE;
      wr_at   = mem_addr;
    end else begin
      if (wr_run >= E_WR) sram[int'(wr_at)] = wr_byte;
      wr_run = 0;
    end

    if (model_on) begin
      e_sel = 0; e_oe_low = 0; e_we_low = 0; e_drive = 0; e_ready = 0; e_done = 0;
      tg = "R1";
      if (m_kind == 0) begin
        e_ready = 1; e_done = m_wdone; tg = m_wdone ? "R6" : "R1";
      end else if (m_kind == 1) begin
        if (m_t < E_RD) begin e_sel = 1; e_oe_low = 1; tg = "R3"; end
        else begin e_done = (m_t == E_RD); tg = e_done ? "R4" : "R5"; end
      end else begin
        tg = "R6"; e_sel = 1; e_drive = 1;
        e_we_low = (m_t >= 1 && m_t <= E_WR);
      end
      chk(mem_sel_n != mem_sel, "R2", "selects opposite", {mem_sel_n, mem_sel}, {!mem_sel, mem_sel});
      chk(mem_sel == e_sel, tg, "select active", mem_sel, e_sel);
      chk(mem_oe_n == !e_oe_low, tg, "mem_oe_n", mem_oe_n, !e_oe_low);
      chk(mem_we_n == !e_we_low, tg, "mem_we_n", mem_we_n, !e_we_low);
      chk(mem_dq_oe == e_drive, "R7", "mem_dq_oe", mem_dq_oe, e_drive);
      chk(req_ready == e_ready, "R8", "req_ready", req_ready, e_ready);
      chk(rsp_done == e_done, tg, "rsp_done", rsp_done, e_done);
      if (e_sel) chk(mem_addr == m_addr, tg, "mem_addr", mem_addr, m_addr);
      if (e_drive) chk(mem_dq_out == m_data, "R6", "mem_dq_out", mem_dq_out, m_data);
      if (m_kind == 1 && m_t == E_RD)
        chk(rsp_rdata == m_data, "R4", "rsp_rdata", rsp_rdata, m_data);
    end
  end

  task automatic issue(input bit wr, input bit [16:0] a, input bit [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000 && !finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    mem_dq_in = 8'h00;
    repeat (4) @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done,
        "R1", "pins in reset", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst_n = 1;
    wait_idle();
    model_on = 1;

    // R9: extremes and middle of the address range.
    issue(1, 17'h00000, 8'h11);
    issue(1, 17'h1FFFF, 8'h9A);
    issue(1, 17'h0AAAA, 8'h55);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    // Write followed at once by a read of the same byte (R7 release before OE).
    issue(1, 17'h12345, 8'hC3);
    issue(0, 17'h12345, 8'h00);
    // Read followed at once by a write (R5 turnaround, R7 gap).
    issue(0, 17'h00100, 8'h00);
    issue(1, 17'h00100, 8'h7E);
    issue(0, 17'h00100, 8'h00);
    // R8: request held while busy must be ignored.
    issue(0, 17'h0AAAA, 8'h00);
    req_valid = 1; req_write = 1; req_addr = 17'h03333; req_wdata = 8'h3C;
    repeat (3) @(negedge clk);
    req_valid = 0;
    wait_idle();
    issue(0, 17'h03333, 8'h00);
    wait_idle();
    chk(!(sram.exists(32'h03333)), "R8", "ignored write stored", sram.exists(32'h03333), 0);
    issue(0, 17'h04000, 8'h00);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(sram[32'h1FFFF] == 8'h9A, "R9", "top byte in memory", sram[32'h1FFFF], 8'h9A);
    summary();
  end

endmodule